// File: doc/BRIEF.md
# Multi-Port Reorder Buffer with Shared Result Buses

This block keeps the program order of instructions in an out-of-order core. At dispatch it hands out entries from a circular store, in order, several per cycle, and records for each one the destination physical register, the mapping that destination replaced, whether the instruction is a store, and (later) whether it is a branch that went the wrong way. Results come back out of order on a set of shared result buses, each carrying the tag of the entry it completes; the block marks that entry done.

Retirement runs from the oldest entry forward, several entries per cycle, and stops at the first entry that has not finished. Retirement traffic is carried on the same buses as results: results always win, and retirement gets whatever buses are idle in that cycle. When a retiring entry carries the wrong-path flag, the block retires it, raises a flush, and discards every younger entry, leaving the buffer empty for the correct path.

Two free-running counters expose how often dispatch was refused for lack of room and the total number of bus slots used, for performance studies.

Top module: `rob_core`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty, no retire lane or flush is raised, `disp_ready` is high when nothing is requested, and both counters read zero.
- R2: Requested dispatch lanes are contiguous from lane 0; lane i of an accepted group takes the tag (tail + i) mod DEPTH, which `disp_tag` shows in the same cycle.
- R3: A dispatch group is taken whole or not at all: when the number of requested lanes exceeds the free entries, `disp_ready` is low, nothing is allocated, and `full_stalls` rises by one on that edge.
- R4: A result on any bus, or on several buses in the same cycle, marks the entry named by its tag done from the next cycle on; results for entries that are not live are ignored.
- R5: Retirement is in order from the head: lane i retires entry (head + i) mod DEPTH, and no entry retires while an older live entry is not done.
- R6: Result buses have priority; the number of retire lanes raised in a cycle never exceeds NBUS minus the number of active result buses.
- R7: Each raised retire lane carries the destination register, the replaced mapping and the store flag that were written at dispatch for that entry.
- R8: When a retiring entry carries the wrong-path flag (set by `wb_mispred` with its result), `flush` is high, that entry retires, no younger lane retires, dispatch is refused in that cycle, and from the next cycle the buffer is empty with the next tag being the one after the flagged entry.
- R9: `bus_use` grows on each edge by the number of active result buses plus the number of raised retire lanes.
- R10: The buffer holds exactly DEPTH entries: after DEPTH allocations without retirement a request for one more entry is refused, and all DEPTH entries can later retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_req | input | NDISP | Dispatch lane requests, contiguous from lane 0 |
| disp_dst | input | NDISP*PREG_W | Destination physical register per lane |
| disp_old | input | NDISP*PREG_W | Previous mapping of that destination per lane |
| disp_store | input | NDISP | Store flag per lane |
| disp_ready | output | 1 | The whole requested group is accepted this cycle |
| disp_tag | output | NDISP*log2(DEPTH) | Tag given to each dispatch lane |
| wb_valid | input | NBUS | Result present on each bus |
| wb_tag | input | NBUS*log2(DEPTH) | Entry completed by each bus |
| wb_mispred | input | NBUS | The completed entry is a wrong-path branch |
| cm_valid | output | NBUS | Retire lane active |
| cm_dst | output | NBUS*PREG_W | Destination register of each retiring entry |
| cm_old | output | NBUS*PREG_W | Replaced mapping of each retiring entry, to be freed |
| cm_store | output | NBUS | Store flag of each retiring entry |
| flush | output | 1 | A retiring entry is a wrong-path branch; younger work is dropped |
| full_stalls | output | CNT_W | Cycles in which dispatch was refused for lack of room |
| bus_use | output | CNT_W | Running total of bus slots used |

## Verification
The bench drives a small configuration (eight entries, four buses, four dispatch lanes) against an arithmetic model and goes after wrap-around of the pointers, the exactly-full buffer, a group one larger than the free room, and results that arrive on several buses while the head is still pending. A design that confused full with empty would accept a ninth entry or refuse a fresh dispatch; one that retired past a pending entry or ignored bus priority would raise too many lanes. The flush cases put the flagged entry in later lanes with a dispatch in the same cycle, so a design that kept younger entries, reused the wrong tail or let that dispatch in would show wrong tags or stray retire lanes afterwards.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes 32 physical registers shared by integer and floating-point work.
package rob_pkg;

    localparam int PREG_W = 5;

    typedef struct packed {
        logic [PREG_W-1:0] dst;    // destination physical register
        logic [PREG_W-1:0] old;    // mapping replaced at rename
        logic              store;  // entry is a store
        logic              mis;    // wrong-path branch seen at writeback
        logic              done;   // result has arrived
    } rob_entry_t;

endpackage

// File: rtl/rob_bus_share.sv
// Bus sharing policy: results own the buses they use; the rest go to retirement.
// Assumes one result per bus per cycle.
module rob_bus_share #(
    parameter int NBUS   = 4,
    parameter int LANE_W = $clog2(NBUS + 1)
) (
    input  logic [NBUS-1:0]   wb_valid,
    output logic [LANE_W-1:0] busy,
    output logic [LANE_W-1:0] free_lanes
);

    // count result buses in use and hand the remainder to retirement
    always_comb begin
        busy = '0;
        for (int b = 0; b < NBUS; b++) begin
            busy = busy + LANE_W'(wb_valid[b]);
        end
        free_lanes = LANE_W'(NBUS) - busy;
    end

endmodule

// File: rtl/rob_retire_pick.sv
// In-order retire selection over the oldest NBUS entries.
// Assumes lane i views entry head+i and that done_ord is already qualified by validity.
module rob_retire_pick #(
    parameter int NBUS   = 4,
    parameter int PTR_W  = 5,
    parameter int LANE_W = $clog2(NBUS + 1)
) (
    input  logic [NBUS-1:0]   done_ord,
    input  logic [NBUS-1:0]   mis_ord,
    input  logic [PTR_W-1:0]  occ,
    input  logic [LANE_W-1:0] free_lanes,
    output logic [NBUS-1:0]   cm_mask,
    output logic              flush,
    output logic [LANE_W-1:0] flush_off
);

    logic go;

    // walk from the head, stop at the first pending entry or the first wrong-path branch
    always_comb begin
        go        = 1'b1;
        cm_mask   = '0;
        flush     = 1'b0;
        flush_off = '0;
        for (int i = 0; i < NBUS; i++) begin
            if (go && (i < int'(free_lanes)) && (i < int'(occ)) && done_ord[i]) begin
                cm_mask[i] = 1'b1;
                if (mis_ord[i]) begin
                    flush     = 1'b1;
                    flush_off = LANE_W'(i);
                    go        = 1'b0;
                end
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rob_stats.sv
// Performance counters: dispatch refusals for lack of room, and bus slots used.
// Assumes counters wrap silently at CNT_W bits.
module rob_stats #(
    parameter int CNT_W  = 32,
    parameter int LANE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_ev,
    input  logic [LANE_W-1:0] busy,
    input  logic [LANE_W-1:0] ncm,
    output logic [CNT_W-1:0]  full_stalls,
    output logic [CNT_W-1:0]  bus_use
);

    // accumulate both counters every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_stalls <= '0;
            bus_use     <= '0;
        end else begin
            full_stalls <= full_stalls + CNT_W'(stall_ev);
            bus_use     <= bus_use + CNT_W'(busy) + CNT_W'(ncm);
        end
    end

endmodule

// File: rtl/rob_core.sv
// Circular reorder buffer: in-order allocation, out-of-order completion on
// NBUS result buses, in-order retirement on the buses results leave idle,
// and flush on a retiring wrong-path branch.
// Assumes DEPTH is a power of two, NBUS <= DEPTH, NDISP <= DEPTH, and that
// dispatch requests are contiguous from lane 0.
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NBUS  = 4,
    parameter int NDISP = 4,
    parameter int CNT_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NDISP-1:0]                 disp_req,
    input  logic [NDISP*PREG_W-1:0]          disp_dst,
    input  logic [NDISP*PREG_W-1:0]          disp_old,
    input  logic [NDISP-1:0]                 disp_store,
    output logic                             disp_ready,
    output logic [NDISP*$clog2(DEPTH)-1:0]   disp_tag,
    input  logic [NBUS-1:0]                  wb_valid,
    input  logic [NBUS*$clog2(DEPTH)-1:0]    wb_tag,
    input  logic [NBUS-1:0]                  wb_mispred,
    output logic [NBUS-1:0]                  cm_valid,
    output logic [NBUS*PREG_W-1:0]           cm_dst,
    output logic [NBUS*PREG_W-1:0]           cm_old,
    output logic [NBUS-1:0]                  cm_store,
    output logic                             flush,
    output logic [CNT_W-1:0]                 full_stalls,
    output logic [CNT_W-1:0]                 bus_use
);

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int PTR_W  = IDX_W + 1;
    localparam int LANE_W = $clog2(NBUS + 1);
    localparam int DREQ_W = $clog2(NDISP + 1);

    rob_entry_t        ent [DEPTH];
    logic [DEPTH-1:0]  vld;
    logic [PTR_W-1:0]  head, tail, occ, flush_ptr;
    logic [IDX_W-1:0]  ord_idx   [NBUS];
    logic [IDX_W-1:0]  wb_idx    [NBUS];
    logic [IDX_W-1:0]  alloc_idx [NDISP];
    logic [NBUS-1:0]   done_ord, mis_ord, cm_mask;
    logic [LANE_W-1:0] busy, free_lanes, ncm, flush_off;
    logic [DREQ_W-1:0] n_req;
    logic              room_ok, accept, stall_ev;

    assign occ = tail - head;

    // per-lane views of the store in retire, writeback and dispatch order
    generate
        for (genvar i = 0; i < NBUS; i++) begin : g_bus
            assign ord_idx[i]  = IDX_W'(head[IDX_W-1:0] + IDX_W'(i));
            assign wb_idx[i]   = wb_tag[i*IDX_W +: IDX_W];
            assign done_ord[i] = vld[ord_idx[i]] && ent[ord_idx[i]].done;
            assign mis_ord[i]  = ent[ord_idx[i]].mis;
            assign cm_dst[i*PREG_W +: PREG_W] = ent[ord_idx[i]].dst;
            assign cm_old[i*PREG_W +: PREG_W] = ent[ord_idx[i]].old;
            assign cm_store[i] = ent[ord_idx[i]].store;
        end
        for (genvar i = 0; i < NDISP; i++) begin : g_disp
            assign alloc_idx[i] = IDX_W'(tail[IDX_W-1:0] + IDX_W'(i));
            assign disp_tag[i*IDX_W +: IDX_W] = alloc_idx[i];
        end
    endgenerate

    rob_bus_share #(.NBUS(NBUS), .LANE_W(LANE_W)) u_share (
        .wb_valid   (wb_valid),
        .busy       (busy),
        .free_lanes (free_lanes)
    );

    rob_retire_pick #(.NBUS(NBUS), .PTR_W(PTR_W), .LANE_W(LANE_W)) u_pick (
        .done_ord   (done_ord),
        .mis_ord    (mis_ord),
        .occ        (occ),
        .free_lanes (free_lanes),
        .cm_mask    (cm_mask),
        .flush      (flush),
        .flush_off  (flush_off)
    );

    // size the dispatch group and decide whether it fits whole
    always_comb begin
        n_req = '0;
        for (int i = 0; i < NDISP; i++) begin
            n_req = n_req + DREQ_W'(disp_req[i]);
        end
        ncm = '0;
        for (int i = 0; i < NBUS; i++) begin
            ncm = ncm + LANE_W'(cm_mask[i]);
        end
        room_ok   = int'(n_req) <= (DEPTH - int'(occ));
        flush_ptr = head + PTR_W'(flush_off) + PTR_W'(1);
    end

    assign disp_ready = room_ok && !flush;
    assign accept     = disp_ready && (|disp_req);
    assign stall_ev   = (|disp_req) && !room_ok;
    assign cm_valid   = cm_mask;

    // entry store and pointers: completion, retirement, flush and allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            vld  <= '0;
        end else begin
            for (int b = 0; b < NBUS; b++) begin
                if (wb_valid[b] && vld[wb_idx[b]]) begin
                    ent[wb_idx[b]].done <= 1'b1;
                    if (wb_mispred[b]) ent[wb_idx[b]].mis <= 1'b1;
                end
            end
            if (flush) begin
                vld  <= '0;
                head <= flush_ptr;
                tail <= flush_ptr;
            end else begin
                for (int i = 0; i < NBUS; i++) begin
                    if (cm_mask[i]) vld[ord_idx[i]] <= 1'b0;
                end
                head <= head + PTR_W'(ncm);
                if (accept) begin
                    for (int i = 0; i < NDISP; i++) begin
                        if (disp_req[i]) begin
                            ent[alloc_idx[i]] <= '{dst:   disp_dst[i*PREG_W +: PREG_W],
                                                   old:   disp_old[i*PREG_W +: PREG_W],
                                                   store: disp_store[i],
                                                   mis:   1'b0,
                                                   done:  1'b0};
                            vld[alloc_idx[i]] <= 1'b1;
                        end
                    end
                    tail <= tail + PTR_W'(n_req);
                end
            end
        end
    end

    rob_stats #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_ev    (stall_ev),
        .busy        (busy),
        .ncm         (ncm),
        .full_stalls (full_stalls),
        .bus_use     (bus_use)
    );

    // R10: the wrap bit keeps occupancy within the store size
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    // R6: results and retirement together never use more buses than exist
    a_r6_bus_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(busy) + int'(ncm)) <= NBUS);

    // R5: retire lanes form an unbroken run from lane 0
    a_r5_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid & (cm_valid + NBUS'(1))) == '0);

    // R5: nothing retires from an empty buffer
    a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (cm_valid == '0));

    // R8: a flush leaves the buffer empty on the next cycle
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (head == tail));

    // R3: a full buffer refuses any request
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(occ) == DEPTH) && (|disp_req)) |-> !disp_ready);

endmodule

// File: tb/sim_rob_core.sv
// Bench for rob_core: directed corner cases then a long pseudo-random sweep,
// all compared against an arithmetic model of the buffer kept in the bench.
module sim_rob_core;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int D  = 8;
    localparam int NB = 4;
    localparam int ND = 4;
    localparam int IW = $clog2(D);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ND-1:0]        disp_req = '0;
    logic [ND*PREG_W-1:0] disp_dst = '0;
    logic [ND*PREG_W-1:0] disp_old = '0;
    logic [ND-1:0]        disp_store = '0;
    logic                 disp_ready;
    logic [ND*IW-1:0]     disp_tag;
    logic [NB-1:0]        wb_valid = '0;
    logic [NB*IW-1:0]     wb_tag = '0;
    logic [NB-1:0]        wb_mispred = '0;
    logic [NB-1:0]        cm_valid;
    logic [NB*PREG_W-1:0] cm_dst;
    logic [NB*PREG_W-1:0] cm_old;
    logic [NB-1:0]        cm_store;
    logic                 flush;
    logic [31:0]          full_stalls;
    logic [31:0]          bus_use;

    rob_core #(.DEPTH(D), .NBUS(NB), .NDISP(ND), .CNT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n),
        .disp_req(disp_req), .disp_dst(disp_dst), .disp_old(disp_old),
        .disp_store(disp_store), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_mispred(wb_mispred),
        .cm_valid(cm_valid), .cm_dst(cm_dst), .cm_old(cm_old), .cm_store(cm_store),
        .flush(flush), .full_stalls(full_stalls), .bus_use(bus_use)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    int m_head = 0, m_tail = 0, m_stall = 0, m_util = 0;
    int m_dst [D], m_old [D];
    bit m_st [D], m_done [D], m_mis [D];

    // stimulus for the next cycle
    int s_nreq = 0;
    bit s_wbv [NB];
    int s_tag [NB];
    bit s_mis [NB];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wb_clear();
        for (int b = 0; b < NB; b++) begin
            s_wbv[b] = 0; s_tag[b] = 0; s_mis[b] = 0;
        end
    endtask

    // result on bus b for the entry rel places after the head
    task automatic wb_set(input int b, input int rel, input bit mis);
        s_wbv[b] = 1; s_tag[b] = (m_head + rel) % D; s_mis[b] = mis;
    endtask

    task automatic step();
        int occ, room, busy, freeb, ncm, fl_off, idx;
        bit go, fl, exp_ready;
        bit expcm [NB];
        @(negedge clk);
        for (int i = 0; i < ND; i++) begin
            disp_req[i] = (i < s_nreq);
            disp_dst[i*PREG_W +: PREG_W] = PREG_W'($urandom);
            disp_old[i*PREG_W +: PREG_W] = PREG_W'($urandom);
            disp_store[i] = 1'($urandom);
        end
        for (int b = 0; b < NB; b++) begin
            wb_valid[b] = s_wbv[b];
            wb_tag[b*IW +: IW] = IW'(s_tag[b]);
            wb_mispred[b] = s_mis[b];
        end
        #1;
        occ = m_tail - m_head;
        room = D - occ;
        busy = 0;
        for (int b = 0; b < NB; b++) busy += int'(s_wbv[b]);
        freeb = NB - busy;
        go = 1; fl = 0; ncm = 0; fl_off = 0;
        for (int i = 0; i < NB; i++) begin
            idx = (m_head + i) % D;
            expcm[i] = 0;
            if (go && i < freeb && i < occ && m_done[idx]) begin
                expcm[i] = 1; ncm++;
                if (m_mis[idx]) begin fl = 1; fl_off = i; go = 0; end
            end else go = 0;
        end
        exp_ready = (s_nreq <= room) && !fl;
        if (occ == D)
            chk(disp_ready == exp_ready, "R10", "disp_ready at full", int'(disp_ready), int'(exp_ready));
        else
            chk(disp_ready == exp_ready, "R3", "disp_ready", int'(disp_ready), int'(exp_ready));
        chk(flush == fl, "R8", "flush", int'(flush), int'(fl));
        for (int i = 0; i < s_nreq; i++)
            chk(int'(disp_tag[i*IW +: IW]) == (m_tail + i) % D, "R2", "disp_tag",
                int'(disp_tag[i*IW +: IW]), (m_tail + i) % D);
        for (int i = 0; i < NB; i++) begin
            // R4 done marking is seen through R5/R6 retire lanes
            chk(cm_valid[i] == expcm[i], (i >= freeb) ? "R6" : "R5", "cm_valid lane",
                int'(cm_valid[i]), int'(expcm[i]));
            if (expcm[i]) begin
                idx = (m_head + i) % D;
                chk(int'(cm_dst[i*PREG_W +: PREG_W]) == m_dst[idx], "R7", "cm_dst",
                    int'(cm_dst[i*PREG_W +: PREG_W]), m_dst[idx]);
                chk(int'(cm_old[i*PREG_W +: PREG_W]) == m_old[idx], "R7", "cm_old",
                    int'(cm_old[i*PREG_W +: PREG_W]), m_old[idx]);
                chk(cm_store[i] == m_st[idx], "R7", "cm_store", int'(cm_store[i]), int'(m_st[idx]));
            end
        end
        @(posedge clk);
        // model update for this edge
        for (int b = 0; b < NB; b++)
            if (s_wbv[b]) begin
                m_done[s_tag[b]] = 1;
                if (s_mis[b]) m_mis[s_tag[b]] = 1;
            end
        if (s_nreq > 0 && s_nreq > room) m_stall++;
        m_util += busy + ncm;
        if (fl) begin
            m_head = m_head + fl_off + 1;
            m_tail = m_head;
        end else begin
            m_head += ncm;
            if (exp_ready && s_nreq > 0) begin
                for (int i = 0; i < s_nreq; i++) begin
                    idx = (m_tail + i) % D;
                    m_dst[idx] = int'(disp_dst[i*PREG_W +: PREG_W]);
                    m_old[idx] = int'(disp_old[i*PREG_W +: PREG_W]);
                    m_st[idx] = disp_store[i];
                    m_done[idx] = 0; m_mis[idx] = 0;
                end
                m_tail += s_nreq;
            end
        end
        #1;
        chk(int'(full_stalls) == m_stall, "R3", "full_stalls", int'(full_stalls), m_stall);
        chk(int'(bus_use) == m_util, "R9", "bus_use", int'(bus_use), m_util);
    endtask

    // pick results for live, unfinished entries at random
    task automatic rand_wb(input int nwb, input int mis_mod);
        int used, occ, idx;
        wb_clear();
        used = 0;
        occ = m_tail - m_head;
        for (int k = 0; k < occ; k++) begin
            idx = (m_head + k) % D;
            if (used < nwb && !m_done[idx] && ($urandom % 3 == 0)) begin
                s_wbv[used] = 1; s_tag[used] = idx;
                s_mis[used] = ($urandom % mis_mod == 0);
                used++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wb_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(disp_ready == 1'b1, "R1", "disp_ready after reset", int'(disp_ready), 1);
        chk(cm_valid == '0, "R1", "cm_valid after reset", int'(cm_valid), 0);
        chk(flush == 1'b0, "R1", "flush after reset", int'(flush), 0);
        chk(full_stalls == 0 && bus_use == 0, "R1", "counters after reset",
            int'(full_stalls + bus_use), 0);
        s_nreq = 0; step();

        // R10 / R3: fill exactly, then ask for one more
        s_nreq = 4; step();
        s_nreq = 4; step();
        s_nreq = 1; step();
        s_nreq = 4; step();

        // R4 / R5: younger results while the head is pending
        s_nreq = 0;
        wb_set(0, 1, 0); wb_set(1, 2, 0); wb_set(2, 3, 0); step();
        wb_clear(); wb_set(0, 0, 0); step();
        wb_clear(); step();

        // R6: results on two buses leave two lanes for retirement
        wb_set(0, 0, 0); wb_set(1, 1, 0); step();
        wb_clear(); wb_set(0, 2, 0); wb_set(1, 3, 0); step();
        wb_clear(); step();
        step();

        // R8: wrong-path branch in lane 1 with a dispatch in the flush cycle
        s_nreq = 4; step();
        s_nreq = 0; wb_set(0, 0, 0); wb_set(1, 1, 1); wb_set(2, 2, 0); step();
        wb_clear(); s_nreq = 2; step();
        s_nreq = 3; step();
        s_nreq = 0; wb_set(0, 2, 1); wb_set(1, 0, 0); wb_set(2, 1, 0); step();
        wb_clear(); s_nreq = 1; step();
        step();

        // sweep: random group sizes, bus loads and occasional wrong-path branches
        for (int c = 0; c < 4000; c++) begin
            s_nreq = $urandom % (ND + 1);
            rand_wb($urandom % (NB + 1), (c < 2000) ? 40 : 12);
            step();
        end
        wb_clear(); s_nreq = 0;
        for (int c = 0; c < 4; c++) step();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule